// File: doc/BRIEF.md
# Gated Sticky Interrupt Status Field

This block is one field of a register file that records hardware events and keeps them until software clears them. An event is captured only while a hardware capture enable is in its active state, so sources that are not being monitored cannot set status bits. The enable polarity is a parameter: it can be active-high or active-low. The enable masks the update and does not change the value that is loaded.

A parameter selects one of five capture modes. Per-bit level mode sets a bit while its input is high. Three per-bit edge modes set a bit on a rising edge, on a falling edge, or on any change of its input. Word mode treats the field as one value: when the field is empty, it loads the whole input word and keeps it. Software reads the held value directly. A write strobe with a data word clears every bit where the data holds a one. An interrupt output is the OR of all held bits.

Top module: `gated_sticky_field`

## Requirements
- R1: While rst_ni is low, status_o and irq_o are 0, and the edge history register is 0.
- R2: A hardware update happens only while the capture gate is active, in every mode. While the gate is inactive, no status bit goes from 0 to 1.
- R3: With ACTIVE_LOW=0 the gate is active when hw_en_i is 1. With ACTIVE_LOW=1 the gate is active when hw_en_i is 0.
- R4: In rising mode, bit i sets at a clock edge where evt_i[i] is 1 and was 0 at the previous edge, provided the gate is active.
- R5: In falling mode, bit i sets at a clock edge where evt_i[i] is 0 and was 1 at the previous edge, provided the gate is active.
- R6: In both-edge mode, bit i sets at a clock edge where evt_i[i] differs from its value at the previous edge, provided the gate is active.
- R7: In per-bit level mode, bit i sets at a clock edge where evt_i[i] is 1, provided the gate is active.
- R8: In word mode, when the field is zero, the gate is active and evt_i is non-zero, the field loads evt_i exactly. While the field is non-zero, hardware input does not change it.
- R9: When sw_clr_i is 1, each status bit whose sw_wdata_i bit is 1 clears at the next edge, and the other bits hold. If a per-bit hardware set and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: The edge history samples evt_i at every edge, whatever the gate state. Turning the gate on while an input stays high therefore creates no rising edge.
- R11: irq_o is 1 exactly when any bit of status_o is 1, in the same cycle.
- R12: Any change to status_o appears after the clock edge that samples the causing inputs, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | WIDTH | Hardware event or status inputs |
| hw_en_i | input | 1 | Capture enable; its polarity is set by ACTIVE_LOW |
| sw_clr_i | input | 1 | Software write strobe for write-one-to-clear |
| sw_wdata_i | input | WIDTH | Clear mask; each 1 clears the matching bit |
| status_o | output | WIDTH | Held field value, the software read path |
| irq_o | output | 1 | OR of all held bits |

## Verification
On every cycle, the assertions check four things: reset leaves the field empty, no bit rises while the gate is inactive, a gated per-bit set always lands, and word mode holds a non-zero value unless software clears it. Write-one-to-clear is also checked against the set that arrives in the same cycle. Only the bench scenarios can show three further behaviours: the exact edge-detection results of each mode, the inverted gate of the active-low variant, and the absence of a false edge when the gate turns on over a steady input. To do so, the bench runs a shared stimulus table through five instances, one per mode, and compares them with a model written from the requirements.

// File: rtl/gsf_pkg.sv
package gsf_pkg;
  typedef enum logic [2:0] {
    STK_LEVEL_WORD = 3'd0,
    STK_LEVEL_BIT  = 3'd1,
    STK_RISE       = 3'd2,
    STK_FALL       = 3'd3,
    STK_BOTH       = 3'd4
  } capture_mode_e;
endpackage

// File: rtl/gsf_edge_det.sv
module gsf_edge_det
  import gsf_pkg::*;
#(
  parameter int            WIDTH = 8,
  parameter capture_mode_e MODE  = STK_RISE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] evt_i,
  output logic [WIDTH-1:0] set_vec_o
);
  localparam bit IsEdge = (MODE == STK_RISE) || (MODE == STK_FALL) || (MODE == STK_BOTH);

  generate
    if (IsEdge) begin : g_edge
      logic [WIDTH-1:0] evt_q;
      // history samples every cycle, independent of the gate
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) evt_q <= '0;
        else         evt_q <= evt_i;
      end
      if (MODE == STK_RISE) begin : g_rise
        assign set_vec_o = evt_i & ~evt_q;
      end else if (MODE == STK_FALL) begin : g_fall
        assign set_vec_o = ~evt_i & evt_q;
      end else begin : g_both
        assign set_vec_o = evt_i ^ evt_q;
      end
    end else begin : g_level
      assign set_vec_o = evt_i;
    end
  endgenerate
endmodule

// File: rtl/gsf_store.sv
module gsf_store
  import gsf_pkg::*;
#(
  parameter int            WIDTH = 8,
  parameter capture_mode_e MODE  = STK_RISE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic [WIDTH-1:0] set_vec_i,
  input  logic [WIDTH-1:0] clr_vec_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] status_q, status_d;

  generate
    if (MODE == STK_LEVEL_WORD) begin : g_word
      always_comb begin
        if (cap_en_i && (status_q == '0) && (set_vec_i != '0)) status_d = set_vec_i;
        else                                                    status_d = status_q & ~clr_vec_i;
      end

      // R8: a held word only changes through a software clear
      a_r8_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_q != '0) && (clr_vec_i == '0)) |=> $stable(status_q));

      // R9
      a_r9_word_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_q != '0) && (clr_vec_i != '0)) |=> ((status_q & $past(clr_vec_i)) == '0));
    end else begin : g_bit
      logic [WIDTH-1:0] hw_set;
      assign hw_set   = cap_en_i ? set_vec_i : '0;
      // hardware set outranks software clear
      assign status_d = (status_q & ~clr_vec_i) | hw_set;

      // R9
      a_r9_bit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_vec_i != '0) |=> ((status_q & $past(clr_vec_i & ~hw_set)) == '0));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;

  // R1
  a_r1_reset_empty: assert property (@(posedge clk_i) !rst_ni |-> (status_q == '0));
endmodule

// File: rtl/gated_sticky_field.sv
module gated_sticky_field
  import gsf_pkg::*;
#(
  parameter int            WIDTH      = 8,
  parameter capture_mode_e MODE       = STK_RISE,
  parameter bit            ACTIVE_LOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] evt_i,
  input  logic             hw_en_i,
  input  logic             sw_clr_i,
  input  logic [WIDTH-1:0] sw_wdata_i,
  output logic [WIDTH-1:0] status_o,
  output logic             irq_o
);
  localparam bit PerBit = (MODE != STK_LEVEL_WORD);

  logic             cap_en;
  logic [WIDTH-1:0] set_vec;
  logic [WIDTH-1:0] clr_vec;

  assign cap_en  = ACTIVE_LOW ? ~hw_en_i : hw_en_i;
  assign clr_vec = sw_clr_i ? sw_wdata_i : '0;

  gsf_edge_det #(.WIDTH(WIDTH), .MODE(MODE)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .set_vec_o (set_vec)
  );

  gsf_store #(.WIDTH(WIDTH), .MODE(MODE)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_en_i  (cap_en),
    .set_vec_i (set_vec),
    .clr_vec_i (clr_vec),
    .status_o  (status_o)
  );

  assign irq_o = |status_o;

  // R2: no bit rises while the gate is closed
  a_r2_gated_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en |=> ((status_o & ~$past(status_o)) == '0));

  generate
    if (PerBit) begin : g_chk_bit
      // R4 R5 R6 R7: a gated per-bit set always lands
      a_r4_bit_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_en |=> ((status_o & $past(set_vec)) == $past(set_vec)));
    end
  endgenerate
endmodule

// File: tb/gated_sticky_field_tb.sv
module gated_sticky_field_tb_top;
  import gsf_pkg::*;

  localparam int W = 4;
  localparam int N = 5;
  localparam int NV = 16;

  localparam capture_mode_e MD [N] = '{STK_RISE, STK_FALL, STK_BOTH, STK_LEVEL_BIT, STK_LEVEL_WORD};
  localparam bit            LOWP [N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam string         TAG [N] = '{"R4", "R5", "R6", "R7_R3", "R8_R3"};

  // {evt[3:0], en, clr, wdata[3:0]}
  localparam logic [9:0] VEC [NV] = '{
    {4'h1, 1'b1, 1'b0, 4'h0}, {4'h1, 1'b0, 1'b0, 4'h0},
    {4'h0, 1'b1, 1'b0, 4'h0}, {4'h6, 1'b0, 1'b0, 4'h0},
    {4'h6, 1'b1, 1'b0, 4'h0}, {4'h9, 1'b1, 1'b0, 4'h0},
    {4'h0, 1'b0, 1'b0, 4'h0}, {4'h0, 1'b1, 1'b1, 4'hF},
    {4'h3, 1'b1, 1'b1, 4'h3}, {4'h3, 1'b0, 1'b1, 4'hF},
    {4'hC, 1'b0, 1'b0, 4'h0}, {4'hC, 1'b1, 1'b1, 4'h5},
    {4'h5, 1'b1, 1'b0, 4'h0}, {4'hA, 1'b0, 1'b1, 4'hA},
    {4'h0, 1'b1, 1'b1, 4'hF}, {4'hF, 1'b0, 1'b1, 4'hF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] evt = '0;
  logic hw_en = 1'b0;
  logic sw_clr = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] st_o [N];
  logic irq_o [N];

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_st [N];
  logic [W-1:0] m_prev;

  always #4 clk = ~clk;

  gated_sticky_field #(.WIDTH(W), .MODE(MD[0]), .ACTIVE_LOW(LOWP[0])) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .hw_en_i(hw_en), .sw_clr_i(sw_clr),
    .sw_wdata_i(wdata), .status_o(st_o[0]), .irq_o(irq_o[0]));
  gated_sticky_field #(.WIDTH(W), .MODE(MD[1]), .ACTIVE_LOW(LOWP[1])) dut_fall (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .hw_en_i(hw_en), .sw_clr_i(sw_clr),
    .sw_wdata_i(wdata), .status_o(st_o[1]), .irq_o(irq_o[1]));
  gated_sticky_field #(.WIDTH(W), .MODE(MD[2]), .ACTIVE_LOW(LOWP[2])) dut_both (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .hw_en_i(hw_en), .sw_clr_i(sw_clr),
    .sw_wdata_i(wdata), .status_o(st_o[2]), .irq_o(irq_o[2]));
  gated_sticky_field #(.WIDTH(W), .MODE(MD[3]), .ACTIVE_LOW(LOWP[3])) dut_lvl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .hw_en_i(hw_en), .sw_clr_i(sw_clr),
    .sw_wdata_i(wdata), .status_o(st_o[3]), .irq_o(irq_o[3]));
  gated_sticky_field #(.WIDTH(W), .MODE(MD[4]), .ACTIVE_LOW(LOWP[4])) dut_word (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .hw_en_i(hw_en), .sw_clr_i(sw_clr),
    .sw_wdata_i(wdata), .status_o(st_o[4]), .irq_o(irq_o[4]));

  function automatic logic [W-1:0] mdl(input capture_mode_e m, input bit lo,
      input logic [W-1:0] s, input logic [W-1:0] p, input logic [W-1:0] e,
      input bit en, input bit c, input logic [W-1:0] w);
    bit g;
    logic [W-1:0] cv, sv;
    g  = lo ? !en : en;
    cv = c ? w : '0;
    if (m == STK_LEVEL_WORD) begin
      if (g && s == '0 && e != '0) return e;
      return s & ~cv;
    end
    case (m)
      STK_RISE: sv = e & ~p;
      STK_FALL: sv = ~e & p;
      STK_BOTH: sv = e ^ p;
      default:  sv = e;
    endcase
    if (!g) sv = '0;
    return (s & ~cv) | sv;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, compare at the next negedge (one register of latency, R12)
  task automatic step(input logic [W-1:0] e, input bit en, input bit c, input logic [W-1:0] w);
    logic [W-1:0] nx [N];
    evt = e; hw_en = en; sw_clr = c; wdata = w;
    for (int k = 0; k < N; k++) nx[k] = mdl(MD[k], LOWP[k], m_st[k], m_prev, e, en, c, w);
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      m_st[k] = nx[k];
      chk(st_o[k] === nx[k], TAG[k], st_o[k], nx[k]);
      chk(irq_o[k] === (|nx[k]), "R11", {3'b0, irq_o[k]}, {3'b0, |nx[k]});
    end
    m_prev = e;
  endtask

  initial begin
    for (int k = 0; k < N; k++) m_st[k] = '0;
    m_prev = '0;
    repeat (3) @(negedge clk);
    // R1: held in reset with gate open and inputs toggling
    evt = 4'hF; hw_en = 1'b1;
    @(negedge clk);
    evt = 4'h0; hw_en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      chk(st_o[k] === '0, "R1", st_o[k], '0);
      chk(irq_o[k] === 1'b0, "R1", {3'b0, irq_o[k]}, 4'h0);
    end
    rst_n = 1'b1;

    // shared stimulus table, R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int v = 0; v < NV; v++)
      step(VEC[v][9:6], VEC[v][5], VEC[v][4], VEC[v][3:0]);

    // R9: same-cycle hardware set and software clear on one bit
    step(4'h0, 1'b1, 1'b1, 4'hF);
    step(4'h0, 1'b1, 1'b1, 4'hF);
    step(4'h1, 1'b1, 1'b1, 4'h1);
    chk(st_o[0] === 4'h1, "R9", st_o[0], 4'h1);

    // R10: gate opens over a steady high input, no false rising edge
    step(4'hF, 1'b0, 1'b1, 4'hF);
    chk(st_o[0] === 4'h0, "R2", st_o[0], 4'h0);
    step(4'hF, 1'b1, 1'b0, 4'h0);
    chk(st_o[0] === 4'h0, "R10", st_o[0], 4'h0);

    // R12: one-edge latency of a fresh rising edge
    step(4'h0, 1'b1, 1'b0, 4'h0);
    evt = 4'h2;
    #1;
    chk(st_o[0] === 4'h0, "R12", st_o[0], 4'h0);
    step(4'h2, 1'b1, 1'b0, 4'h0);
    chk(st_o[0] === 4'h2, "R12", st_o[0], 4'h2);

    // R3: active-low word field loads only with hw_en low
    step(4'h0, 1'b0, 1'b1, 4'hF);
    step(4'h7, 1'b1, 1'b0, 4'h0);
    chk(st_o[4] === 4'h0, "R3", st_o[4], 4'h0);
    step(4'h7, 1'b0, 1'b0, 4'h0);
    chk(st_o[4] === 4'h7, "R8", st_o[4], 4'h7);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule